// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the odd partial syndromes of one BCH codeword into the complete list of 2t syndromes over GF(2^m). It is used on the read path of a flash error-correction engine. An upstream stage has already reduced the received codeword into one partial remainder per odd syndrome. This unit evaluates each remainder at the matching power of alpha, then forms every even syndrome by squaring a lower one. The error-locator solver that follows then finds all 2t values at a read port indexed by syndrome number.

The partial remainders sit in a word-addressed store, two 16-bit values per 32-bit word. The unit drives a word address and reads the data in the same cycle. A start pulse latches the field size and the strength code. Once the last syndrome is stored, a one-cycle done pulse follows. Odd syndromes are accumulated bit-serially by Horner's rule through a single shift-and-reduce multiplier. The same multiplier then squares the results in the even phase.

Top module: `synd_expand`

## Requirements
- R1: `m_sel`=0 selects GF(2^13) with reduction polynomial 0x201B; `m_sel`=1 selects GF(2^14) with polynomial 0x4443. Alpha is the element 2 (the polynomial x). `m_sel` is sampled only on an accepted start.
- R2: `t_code` is sampled on an accepted start. It picks t as follows: 0→2, 1→4, 2→8, 3→12, 4→24, 5→32. Codes 6 and 7 behave as code 5. A value above the parameter T_MAX is clamped to T_MAX.
- R3: The unit drives word address w on `pw_addr`. Partial 2w is taken from `pw_data[15:0]` and partial 2w+1 from `pw_data[31:16]`. Partial k (0-based) produces syndrome S_(2k+1).
- R4: Each odd syndrome S_i is the XOR of alpha^(i*j) over the bit positions j < m that are set in its partial value. Bits m and above of each 16-bit partial are ignored.
- R5: Each even syndrome S_2j equals S_j squared in the selected field, so S_2j is zero whenever S_j is zero.
- R6: Count the clock edge that accepts start as edge 0. `done` is then high for exactly one cycle, following edge t*m+t+1. `busy` is high from edge 0 until that same edge.
- R7: While `busy` is high, `start` is ignored, as are changes on `m_sel` and `t_code`. A start given in the cycle that `done` is high is accepted.
- R8: `rd_syn` shows the syndrome numbered `rd_idx` (1 to 2t) combinationally. Index 0 and indices above 2t read zero, because an accepted start clears every entry. Values hold until the next accepted start.
- R9: After reset, `busy` and `done` are low and every index reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an expansion (accepted when idle) |
| m_sel | input | 1 | Field select: 0 for m=13, 1 for m=14 |
| t_code | input | 3 | Correction strength code |
| pw_addr | output | $clog2(T_MAX/2) | Word address of the partial-syndrome store |
| pw_data | input | 32 | Two packed partial syndromes at `pw_addr` |
| rd_idx | input | $clog2(2*T_MAX+1) | Syndrome number to read |
| rd_syn | output | 14 | Syndrome value at `rd_idx` |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The done pulse of one expansion and the acceptance of the next start can fall in the same cycle. This happens when software chains sectors back to back. The bench provokes it by raising start in the very cycle it first sees done. It then judges the case on three points: busy must be high one cycle later, the second run must keep the full latency, and every entry above the new 2t must read zero. A start pulse in the middle of a run, carrying a different field and strength, tests the opposite case. That run's results and latency must come out unchanged.

// File: rtl/synd_expand.sv
module synd_expand #(
  parameter int T_MAX = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              m_sel,
  input  logic [2:0]                        t_code,
  output logic [$clog2(T_MAX/2)-1:0]        pw_addr,
  input  logic [31:0]                       pw_data,
  input  logic [$clog2(2*T_MAX+1)-1:0]      rd_idx,
  output logic [13:0]                       rd_syn,
  output logic                              busy,
  output logic                              done
);
  localparam int NSYN = 2 * T_MAX;
  localparam int IW   = $clog2(NSYN + 1);
  localparam int AW   = $clog2(T_MAX / 2);
  localparam int KW   = $clog2(T_MAX);
  localparam int JW   = $clog2(T_MAX + 1);
  localparam int SW   = $clog2(NSYN);

  typedef enum logic [1:0] {IDLE, ODD, EVEN, FIN} st_t;

  function automatic logic [13:0] gf_mul(input logic [13:0] a, input logic [13:0] b, input logic big);
    logic [14:0] r;
    r = '0;
    for (int k = 13; k >= 0; k--) begin
      r = {r[13:0], 1'b0};
      if (big) begin
        if (r[14]) r = r ^ 15'h4443;
      end else if (r[13]) begin
        r = r ^ 15'h201B;
      end
      if (b[k]) r = r ^ {1'b0, a};
    end
    return r[13:0];
  endfunction

  function automatic logic [13:0] times_alpha(input logic [13:0] a, input logic big);
    logic [14:0] r;
    r = {a, 1'b0};
    if (big) begin
      if (r[14]) r = r ^ 15'h4443;
    end else if (r[13]) begin
      r = r ^ 15'h201B;
    end
    return r[13:0];
  endfunction

  function automatic logic [JW-1:0] dec_t(input logic [2:0] c);
    int v;
    case (c)
      3'd0:    v = 2;
      3'd1:    v = 4;
      3'd2:    v = 8;
      3'd3:    v = 12;
      3'd4:    v = 24;
      default: v = 32;
    endcase
    if (v > T_MAX) v = T_MAX;
    return JW'(v);
  endfunction

  st_t            st;
  logic           m14;
  logic [JW-1:0]  t_lat;
  logic [KW-1:0]  kidx;
  logic [JW-1:0]  jcnt;
  logic [3:0]     bcnt;
  logic [13:0]    acc, beta;
  logic [13:0]    syn [NSYN];
  logic           done_q;

  logic [15:0]    part;
  logic           pbit;
  logic [13:0]    sq_in, mul_a, mul_b, prod, horner;

  assign part    = kidx[0] ? pw_data[31:16] : pw_data[15:0];
  assign pbit    = part[bcnt];
  assign sq_in   = syn[SW'(jcnt - 1'b1)];
  assign mul_a   = (st == EVEN) ? sq_in : acc;
  assign mul_b   = (st == EVEN) ? sq_in : beta;
  assign prod    = gf_mul(mul_a, mul_b, m14);
  assign horner  = prod ^ {13'b0, pbit};

  assign pw_addr = (st == ODD) ? AW'(kidx >> 1) : '0;
  assign rd_syn  = (rd_idx == '0 || rd_idx > IW'(NSYN)) ? '0 : syn[SW'(rd_idx - 1'b1)];
  assign busy    = (st != IDLE);
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      m14    <= 1'b0;
      t_lat  <= '0;
      kidx   <= '0;
      jcnt   <= '0;
      bcnt   <= '0;
      acc    <= '0;
      beta   <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NSYN; i++) syn[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st    <= ODD;
          m14   <= m_sel;
          t_lat <= dec_t(t_code);
          kidx  <= '0;
          bcnt  <= m_sel ? 4'd13 : 4'd12;
          acc   <= '0;
          beta  <= 14'd2;
          for (int i = 0; i < NSYN; i++) syn[i] <= '0;
        end
        ODD: begin
          if (bcnt == 4'd0) begin
            syn[SW'({kidx, 1'b0})] <= horner;
            acc  <= '0;
            beta <= times_alpha(times_alpha(beta, m14), m14);
            bcnt <= m14 ? 4'd13 : 4'd12;
            if (JW'(kidx) == t_lat - 1'b1) begin
              st   <= EVEN;
              jcnt <= JW'(1);
            end else begin
              kidx <= kidx + 1'b1;
            end
          end else begin
            acc  <= horner;
            bcnt <= bcnt - 1'b1;
          end
        end
        EVEN: begin
          syn[SW'({jcnt, 1'b0} - 1'b1)] <= prod;
          if (jcnt == t_lat) st <= FIN;
          else jcnt <= jcnt + 1'b1;
        end
        FIN: begin
          done_q <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end
endmodule

module synd_expand_chk #(
  parameter int T_MAX = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [$clog2(T_MAX/2)-1:0]   pw_addr,
  input logic [$clog2(2*T_MAX+1)-1:0] rd_idx,
  input logic [13:0]                  rd_syn
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy));
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R3
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> pw_addr == '0);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (rd_idx != $past(rd_idx)) || (rd_syn == $past(rd_syn)));
endmodule

bind synd_expand synd_expand_chk #(.T_MAX(T_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pw_addr(pw_addr), .rd_idx(rd_idx), .rd_syn(rd_syn)
);

// File: tb/synd_expand_test.sv
`timescale 1ns/1ps
module synd_expand_test;
  localparam int T_MAX = 32;
  localparam int NSYN  = 2 * T_MAX;
  localparam int IW    = $clog2(NSYN + 1);
  localparam int AW    = $clog2(T_MAX / 2);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, m_sel = 1'b0;
  logic [2:0] t_code = '0;
  logic [AW-1:0] pw_addr;
  logic [31:0] pw_data;
  logic [IW-1:0] rd_idx = '0;
  logic [13:0] rd_syn;
  logic busy, done;

  logic [31:0] words [T_MAX/2];
  logic [13:0] expv [NSYN+1];
  int checks = 0, errors = 0;
  bit finished = 0;

  assign pw_data = words[pw_addr];

  always #2.5 clk = ~clk;

  synd_expand #(.T_MAX(T_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_sel(m_sel), .t_code(t_code),
    .pw_addr(pw_addr), .pw_data(pw_data), .rd_idx(rd_idx), .rd_syn(rd_syn),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] b_xt(input logic [13:0] a, input logic big);
    logic [14:0] r;
    r = {a, 1'b0};
    if (big && r[14]) r = r ^ 15'h4443;
    if (!big && r[13]) r = r ^ 15'h201B;
    return r[13:0];
  endfunction

  function automatic logic [13:0] b_apow(input int e, input logic big);
    logic [13:0] r;
    int n;
    n = big ? 16383 : 8191;
    r = 14'd1;
    for (int s = 0; s < e % n; s++) r = b_xt(r, big);
    return r;
  endfunction

  function automatic logic [13:0] b_mul(input logic [13:0] a, input logic [13:0] b, input logic big);
    logic [13:0] r, x;
    r = '0;
    x = a;
    for (int k = 0; k < 14; k++) begin
      if (b[k]) r = r ^ x;
      x = b_xt(x, big);
    end
    return r;
  endfunction

  function automatic int t_of(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  // expected values from the partials held in words[] (R3 packing, R4 sums, R5 squares)
  task automatic build_exp(input logic big, input int t);
    int m;
    logic [15:0] p;
    m = big ? 14 : 13;
    for (int i = 0; i <= NSYN; i++) expv[i] = '0;
    for (int k = 0; k < t; k++) begin
      p = (k % 2) ? words[k/2][31:16] : words[k/2][15:0];
      for (int j = 0; j < m; j++)
        if (p[j]) expv[2*k+1] = expv[2*k+1] ^ b_apow((2*k+1)*j, big);
    end
    for (int j = 1; j <= t; j++) expv[2*j] = b_mul(expv[j], expv[j], big);
  endtask

  task automatic kick(input logic big, input logic [2:0] code);
    m_sel = big;
    t_code = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int lat, input int poke, input bit tail);
    int cnt;
    cnt = 0;
    chk({tag, " R6 busy after start"}, busy, 1);
    while (!done && cnt < 4000) begin
      @(negedge clk);
      cnt++;
      if (poke != 0 && cnt == poke) begin
        start = 1'b1; m_sel = ~m_sel; t_code = 3'd5;
      end
      if (poke != 0 && cnt == poke + 1) start = 1'b0;
    end
    chk({tag, " R6 latency"}, cnt, lat);
    if (tail) begin
      @(negedge clk);
      chk({tag, " R6 done one cycle"}, done, 0);
      chk({tag, " R6 busy low"}, busy, 0);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i <= NSYN; i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      #1;
      chk($sformatf("%s R8 idx %0d", tag, i), rd_syn, expv[i]);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    rd_idx = IW'(1); #1;
    chk("R9 idx1", rd_syn, 0);
    rd_idx = IW'(NSYN); #1;
    chk("R9 idx top", rd_syn, 0);
  endtask

  task automatic t_random(input logic big, input logic [2:0] code, input string tag);
    int t, m;
    t = t_of(code); m = big ? 14 : 13;
    for (int w = 0; w < T_MAX/2; w++) words[w] = $urandom;
    build_exp(big, t);
    @(negedge clk);
    kick(big, code);
    wait_done({tag, " R1 R2"}, t*m + t + 1, 0, 1);
    check_all({tag, " R3 R4 R5"});
  endtask

  task automatic t_errpoly(input logic big, input string tag);
    logic [15:0] r;
    int pos [4];
    int m;
    m = big ? 14 : 13;
    pos = '{0, 3, 7, m-1};
    r = '0;
    for (int e = 0; e < 4; e++) r[pos[e]] = 1'b1;
    for (int w = 0; w < T_MAX/2; w++) words[w] = {r, r};
    for (int k = 0; k <= NSYN; k++) begin
      expv[k] = '0;
      if (k > 0) for (int e = 0; e < 4; e++) expv[k] = expv[k] ^ b_apow(k*pos[e], big);
    end
    @(negedge clk);
    kick(big, 3'd5);
    wait_done({tag, " R1"}, 32*m + 33, 0, 1);
    check_all({tag, " R1 R4 R5 direct"});
  endtask

  task automatic t_zero;
    for (int w = 0; w < T_MAX/2; w++) words[w] = 32'hC000_C000;
    for (int k = 0; k <= NSYN; k++) expv[k] = '0;
    @(negedge clk);
    kick(1'b1, 3'd2);
    wait_done("zero R4", 8*14 + 9, 0, 1);
    check_all("zero R4 R5 high bits ignored");
  endtask

  task automatic t_busy_start;
    for (int w = 0; w < T_MAX/2; w++) words[w] = $urandom;
    build_exp(1'b0, 4);
    @(negedge clk);
    kick(1'b0, 3'd1);
    wait_done("poke R7", 4*13 + 5, 10, 1);
    check_all("poke R7 result");
  endtask

  task automatic t_chain;
    t_errpoly(1'b1, "first");
    for (int w = 0; w < T_MAX/2; w++) words[w] = $urandom;
    @(negedge clk);
    kick(1'b1, 3'd5);
    wait_done("chain first R7", 32*14 + 33, 0, 0);
    build_exp(1'b0, 2);
    kick(1'b0, 3'd0);
    wait_done("chain second R7", 2*13 + 3, 0, 1);
    check_all("chain R8 cleared above 2t");
  endtask

  task automatic t_hold;
    repeat (20) @(negedge clk);
    rd_idx = IW'(3); #1;
    chk("hold R8 idx3", rd_syn, expv[3]);
    rd_idx = IW'(4); #1;
    chk("hold R8 idx4", rd_syn, expv[4]);
  endtask

  task automatic t_decode;
    for (int w = 0; w < T_MAX/2; w++) words[w] = $urandom;
    @(negedge clk);
    kick(1'b0, 3'd7);
    wait_done("code7 R2", 32*13 + 33, 0, 1);
    build_exp(1'b0, 12);
    @(negedge clk);
    kick(1'b0, 3'd3);
    wait_done("code3 R2", 12*13 + 13, 0, 1);
    check_all("code3 R2");
  endtask

  initial begin
    for (int w = 0; w < T_MAX/2; w++) words[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_random(1'b0, 3'd0, "m13 t2");
    t_random(1'b1, 3'd2, "m14 t8");
    t_random(1'b0, 3'd4, "m13 t24");
    t_errpoly(1'b0, "ep13");
    t_errpoly(1'b1, "ep14");
    t_zero();
    t_busy_start();
    t_chain();
    t_hold();
    t_decode();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule